// File: doc/BRIEF.md
# CAN Identifier Acceptance Mask Filter

This block decides which receive mailboxes of a CAN controller accept an incoming frame. Each mailbox holds a 32-bit identifier word. The received frame arrives as an identifier word in the same layout. A mask register selects which identifier bits the filter compares. One shared mask serves the lower mailboxes, and each of the two highest mailboxes has a mask of its own. The result is a per-mailbox match vector, a hit flag and the index of the lowest-numbered matching mailbox. All three are registered one clock after the frame is presented.

The identifier word layout is fixed. Bits 31..21 carry the base identifier ID[28:18]. Bit 20 is SRR for extended frames and RTR for standard frames. Bit 19 is IDE (1 = extended). Bits 18..1 carry ID[17:0], and bit 0 is the extended-frame RTR. The masks are written and read over a small host port. Some positions are forced: the IDE position is always 1, and positions 20 and 0 are always 0.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, all three masks read back as 0xFFEF_FFFE.
- R2: A host write with address 0 (shared mask), 1 (mailbox 14 mask) or 2 (mailbox 15 mask) takes effect at the next clock edge. The stored and read-back value has bit 19 forced to 1 and bits 20 and 0 forced to 0, whatever was written.
- R3: Where a mask bit is 1, the frame bit must equal the mailbox bit. Where a mask bit is 0, that bit is don't-care.
- R4: Mailboxes 0 to 13 use the shared mask, mailbox 14 uses mask 1 and mailbox 15 uses mask 2. Writes to address 3 change nothing, and reads from address 3 return 0.
- R5: The IDE bit is always compared. A standard frame never matches a mailbox whose word has IDE = 1, and an extended frame never matches one with IDE = 0.
- R6: Bits 20 and 0 of the frame and mailbox words are never compared.
- R7: For a standard frame (IDE = 0), bits 18..1 are not compared, whatever the mask holds.
- R8: A remote frame is accepted by no mailbox. A remote frame is a standard frame with bit 20 = 1 or an extended frame with bit 0 = 1.
- R9: A mailbox whose enable bit is 0 never matches.
- R10: The outputs res_valid, match_vec, hit_valid and hit_idx reflect the frame presented with rx_valid one clock earlier. Without rx_valid, the match vector and hit flag are 0.
- R11: hit_valid is 1 exactly when any match bit is set. hit_idx is then the lowest set position.
- R12: A frame presented in the same cycle as a mask write is judged against the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Mask write strobe |
| host_addr | input | 2 | Mask select for read and write |
| host_wdata | input | 32 | Mask write data |
| host_rdata | output | 32 | Mask read data for host_addr |
| rx_valid | input | 1 | A received frame identifier is presented |
| rx_id_word | input | 32 | Received identifier word |
| mb_id_flat | input | 512 | Stored identifier words, mailbox i at bits 32*i+31..32*i |
| mb_rx_en | input | 16 | Per-mailbox receive enable |
| res_valid | output | 1 | Result of the frame one cycle earlier is valid |
| match_vec | output | 16 | Per-mailbox match result |
| hit_valid | output | 1 | At least one mailbox matched |
| hit_idx | output | 4 | Lowest matching mailbox |

## Verification
A host mask write and a frame comparison can fall in the same clock cycle. The comparison then has to use the mask held before the write, while the new value is visible only from the next edge. The bench provokes this by driving a write strobe and rx_valid on the same edge. In some cases the old and new mask give different match vectors. The scoreboard queues the expected result from its shadow mask before it updates that shadow. The monitor then checks the registered vector, the hit flag and the index against it. Random frames mixed with mask writes repeat this overlap beyond the directed cases.

// File: rtl/can_flt_pkg.sv
// Package: shared constants and helpers for the acceptance filter.
// Assumes the 32-bit identifier word layout given in the brief.
package can_flt_pkg;
    localparam int          WORD_W    = 32;
    localparam int          IDE_POS   = 19;
    localparam int          SRR_POS   = 20;
    localparam int          XRTR_POS  = 0;
    localparam logic [31:0] MASK_RST  = 32'hFFEF_FFFE;
    localparam logic [31:0] EXT_BITS  = 32'h0007_FFFE;
    localparam logic [31:0] SET_BITS  = 32'h0008_0000;
    localparam logic [31:0] CLR_BITS  = 32'h0010_0001;

    // Apply the hard-wired mask positions to a host value.
    function automatic logic [31:0] force_mask(input logic [31:0] w);
        return (w | SET_BITS) & ~CLR_BITS;
    endfunction

    // A frame is remote when its format-dependent RTR bit is set.
    function automatic logic is_remote(input logic [31:0] w);
        return w[IDE_POS] ? w[XRTR_POS] : w[SRR_POS];
    endfunction
endpackage

// File: rtl/can_mask_regs.sv
// Mask register file: NUM_MASK masks on a simple host port.
// Writes land at the next clock edge; reads are combinational.
// Assumes addresses at or above NUM_MASK are unmapped.
module can_mask_regs
    import can_flt_pkg::*;
#(
    parameter int NUM_MASK = 3,
    parameter int AW       = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          rdata,
    output logic [NUM_MASK*WORD_W-1:0] masks_flat
);
    logic [WORD_W-1:0] mask_q [NUM_MASK];

    for (genvar k = 0; k < NUM_MASK; k++) begin : g_mask
        // Hold one mask; apply forced bits when it is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[k] <= MASK_RST;
            else if (wr_en && addr == AW'(k))
                mask_q[k] <= force_mask(wdata);
        end
        assign masks_flat[k*WORD_W +: WORD_W] = mask_q[k];
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_MASK; k++)
            if (addr == AW'(k))
                rdata = mask_q[k];
    end
endmodule

// File: rtl/can_mb_compare.sv
// Single-mailbox compare: masked identifier equality with IDE always
// checked, RTR/SRR never checked, extended bits skipped for standard
// frames, and remote frames and disabled mailboxes rejected.
// Assumes the mask already carries its forced bits.
module can_mb_compare
    import can_flt_pkg::*;
(
    input  logic              frame_ok,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] mb_word,
    input  logic [WORD_W-1:0] mask,
    input  logic              mb_en,
    output logic              hit
);
    logic [WORD_W-1:0] eff_mask;
    logic [WORD_W-1:0] diff;

    // Build the effective mask for this frame format.
    always_comb begin
        eff_mask           = mask;
        eff_mask[IDE_POS]  = 1'b1;
        eff_mask[SRR_POS]  = 1'b0;
        eff_mask[XRTR_POS] = 1'b0;
        if (!rx_word[IDE_POS])
            eff_mask = eff_mask & ~EXT_BITS;
    end

    // Compare the masked difference and gate with frame and enable.
    always_comb begin
        diff = (rx_word ^ mb_word) & eff_mask;
        hit  = frame_ok && mb_en && (diff == '0);
    end
endmodule

// File: rtl/can_lowest_pick.sv
// Priority picker: reports whether any bit is set and the lowest index.
// Assumes N fits in IW bits.
module can_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
// Acceptance filter top: mask registers, per-mailbox compare, lowest-hit
// pick, and a single output register stage.
// Assumes the top NUM_DED mailboxes each own a dedicated mask and the
// rest share mask 0.
module can_accept_filter
    import can_flt_pkg::*;
#(
    parameter  int NUM_MB   = 16,
    parameter  int NUM_DED  = 2,
    localparam int NUM_MASK = NUM_DED + 1,
    localparam int AW       = $clog2(NUM_MASK),
    localparam int IW       = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr_en,
    input  logic [AW-1:0]            host_addr,
    input  logic [31:0]              host_wdata,
    output logic [31:0]              host_rdata,
    input  logic                     rx_valid,
    input  logic [31:0]              rx_id_word,
    input  logic [NUM_MB*32-1:0]     mb_id_flat,
    input  logic [NUM_MB-1:0]        mb_rx_en,
    output logic                     res_valid,
    output logic [NUM_MB-1:0]        match_vec,
    output logic                     hit_valid,
    output logic [IW-1:0]            hit_idx
);
    localparam int FIRST_DED = NUM_MB - NUM_DED;

    logic [NUM_MASK*WORD_W-1:0] masks_flat;
    logic [NUM_MB-1:0]          hit_raw;
    logic                       any_raw;
    logic [IW-1:0]              idx_raw;
    logic                       frame_ok;

    can_mask_regs #(.NUM_MASK(NUM_MASK), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .rdata      (host_rdata),
        .masks_flat (masks_flat)
    );

    // A frame qualifies for comparison only when valid and not remote.
    assign frame_ok = rx_valid && !is_remote(rx_id_word);

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        localparam int MSEL = (i < FIRST_DED) ? 0 : (i - FIRST_DED + 1);
        can_mb_compare u_cmp (
            .frame_ok (frame_ok),
            .rx_word  (rx_id_word),
            .mb_word  (mb_id_flat[i*WORD_W +: WORD_W]),
            .mask     (masks_flat[MSEL*WORD_W +: WORD_W]),
            .mb_en    (mb_rx_en[i]),
            .hit      (hit_raw[i])
        );
    end

    can_lowest_pick #(.N(NUM_MB), .IW(IW)) u_pick (
        .vec (hit_raw),
        .any (any_raw),
        .idx (idx_raw)
    );

    // Register the comparison result once before the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            match_vec <= '0;
            hit_valid <= 1'b0;
            hit_idx   <= '0;
        end else begin
            res_valid <= rx_valid;
            match_vec <= hit_raw;
            hit_valid <= any_raw;
            hit_idx   <= idx_raw;
        end
    end
endmodule

// File: rtl/can_accept_filter_chk.sv
// Checker for the acceptance filter, bound to every instance of the top.
// Assumes the identifier layout of the brief and synchronous reset.
module can_accept_filter_chk #(
    parameter  int NUM_MB   = 16,
    parameter  int NUM_DED  = 2,
    localparam int NUM_MASK = NUM_DED + 1,
    localparam int AW       = $clog2(NUM_MASK),
    localparam int IW       = $clog2(NUM_MB)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AW-1:0]        host_addr,
    input logic [31:0]          host_rdata,
    input logic                 rx_valid,
    input logic [31:0]          rx_id_word,
    input logic [NUM_MB-1:0]    mb_rx_en,
    input logic                 res_valid,
    input logic [NUM_MB-1:0]    match_vec,
    input logic                 hit_valid,
    input logic [IW-1:0]        hit_idx
);
    p_rd_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(host_addr) < NUM_MASK) |->
            (host_rdata[19] && !host_rdata[20] && !host_rdata[0]));

    p_remote_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_id_word[19] ? rx_id_word[0] : rx_id_word[20]))
            |=> (match_vec == '0));

    p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ((match_vec & ~$past(mb_rx_en)) == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (match_vec == '0 && !hit_valid));

    p_res_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> res_valid);

    p_hit_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid == (match_vec != '0));

    p_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (match_vec[hit_idx] &&
            ((match_vec & ((NUM_MB'(1) << hit_idx) - NUM_MB'(1))) == '0)));
endmodule

bind can_accept_filter can_accept_filter_chk #(
    .NUM_MB  (NUM_MB),
    .NUM_DED (NUM_DED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .rx_valid   (rx_valid),
    .rx_id_word (rx_id_word),
    .mb_rx_en   (mb_rx_en),
    .res_valid  (res_valid),
    .match_vec  (match_vec),
    .hit_valid  (hit_valid),
    .hit_idx    (hit_idx)
);

// File: tb/tb_can_accept_filter.sv
// Scoreboard bench: driver tasks queue expected results computed from a
// shadow model of the requirements; a monitor pops and compares them.
module tb_can_accept_filter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr_en = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         rx_valid = 1'b0;
    logic [31:0]  rx_id_word = '0;
    logic [511:0] mb_id_flat;
    logic [15:0]  mb_rx_en = 16'hFFFF;
    logic         res_valid;
    logic [15:0]  match_vec;
    logic         hit_valid;
    logic [3:0]   hit_idx;

    typedef struct packed {
        logic [15:0] vec;
        logic        hv;
        logic [3:0]  idx;
    } exp_t;

    exp_t        exp_q [$];
    string       tag_q [$];
    logic [31:0] mbid [16];
    logic [31:0] sm   [3];
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    can_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_valid(rx_valid),
        .rx_id_word(rx_id_word), .mb_id_flat(mb_id_flat),
        .mb_rx_en(mb_rx_en), .res_valid(res_valid),
        .match_vec(match_vec), .hit_valid(hit_valid), .hit_idx(hit_idx)
    );

    always_comb
        for (int i = 0; i < 16; i++) mb_id_flat[i*32 +: 32] = mbid[i];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected model built from R3..R9 and R11.
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [31:0] m;
        logic remote;
        e = '0;
        remote = w[19] ? w[0] : w[20];
        for (int i = 0; i < 16; i++) begin
            m = (i < 14) ? sm[0] : (i == 14 ? sm[1] : sm[2]);
            m = (m | 32'h0008_0000) & ~32'h0010_0001;
            if (!w[19]) m = m & ~32'h0007_FFFE;
            e.vec[i] = mb_rx_en[i] && !remote && (((w ^ mbid[i]) & m) == 0);
        end
        for (int i = 15; i >= 0; i--)
            if (e.vec[i]) begin e.hv = 1'b1; e.idx = 4'(i); end
        return e;
    endfunction

    function automatic logic [31:0] forced(input logic [31:0] d);
        return (d | 32'h0008_0000) & ~32'h0010_0001;
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        if (a < 3) sm[a] = forced(d);
    endtask

    task automatic host_read(input logic [1:0] a, input logic [31:0] exp,
                             input string tag);
        host_addr = a;
        #1;
        check(host_rdata == exp, tag, host_rdata, exp);
    endtask

    task automatic send(input logic [31:0] w, input string tag);
        exp_q.push_back(model(w));
        tag_q.push_back(tag);
        rx_valid = 1'b1; rx_id_word = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // R12: a frame and a mask write in the same cycle use the old mask.
    task automatic send_with_write(input logic [31:0] w, input logic [1:0] a,
                                   input logic [31:0] d, input string tag);
        exp_q.push_back(model(w));
        tag_q.push_back(tag);
        rx_valid = 1'b1; rx_id_word = w;
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        rx_valid = 1'b0; host_wr_en = 1'b0;
        if (a < 3) sm[a] = forced(d);
    endtask

    // Monitor: compare each registered result with the queued one (R10).
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", 32'(match_vec), 0);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(match_vec == e.vec, {t, " vec"}, 32'(match_vec), 32'(e.vec));
                check(hit_valid == e.hv, {t, " R11 hit"}, 32'(hit_valid), 32'(e.hv));
                if (e.hv)
                    check(hit_idx == e.idx, {t, " R11 idx"}, 32'(hit_idx), 32'(e.idx));
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++)
            mbid[i] = {11'(i*37 + 5), 1'b0, 1'b1, 18'(i*1013 + 9), 1'b0};
        mbid[2] = {11'h123, 1'b0, 1'b0, 18'h0, 1'b0};
        for (int k = 0; k < 3; k++) sm[k] = 32'hFFEF_FFFE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        host_read(2'd0, 32'hFFEF_FFFE, "R1 mask0 reset");
        host_read(2'd1, 32'hFFEF_FFFE, "R1 mask1 reset");
        host_read(2'd2, 32'hFFEF_FFFE, "R1 mask2 reset");
        check(!res_valid && match_vec == 0, "R10 reset outputs", 32'(match_vec), 0);

        send(mbid[5], "R3 exact ext hit");
        mb_rx_en[5] = 1'b0;
        send(mbid[5], "R9 disabled mailbox");
        mb_rx_en[5] = 1'b1;
        send(mbid[5] | 32'h0010_0000, "R6 SRR ignored");
        send(mbid[5] | 32'h0000_0001, "R8 ext remote");
        send({11'h123, 1'b0, 1'b0, 18'h2AAAA, 1'b0}, "R7 std ext bits skipped");
        send({11'h123, 1'b1, 1'b0, 18'h0, 1'b0}, "R8 std remote");

        host_write(2'd0, 32'h0000_0000);
        host_read(2'd0, 32'h0008_0000, "R2 forced readback");
        send({11'h7FF, 1'b0, 1'b1, 18'h3FFFF, 1'b0}, "R5 R4 ext all shared");
        send({11'h7FF, 1'b0, 1'b0, 18'h0, 1'b0}, "R5 std vs ext");

        host_write(2'd0, 32'hFFFF_FFFF);
        host_read(2'd0, 32'hFFEF_FFFE, "R2 forced set readback");
        host_write(2'd0, 32'hFFE0_0000);
        host_read(2'd0, 32'hFFE8_0000, "R2 partial mask");
        send({mbid[7][31:19], 18'h15555, 1'b0}, "R3 low bits don't care");

        host_write(2'd2, 32'h0000_0000);
        send({11'h001, 1'b0, 1'b1, 18'h00001, 1'b0}, "R4 mb15 own mask");
        host_write(2'd3, 32'h0000_0000);
        host_read(2'd3, 32'h0, "R4 addr3 reads zero");
        host_read(2'd0, 32'hFFE8_0000, "R4 addr3 no effect m0");
        host_read(2'd1, 32'hFFEF_FFFE, "R4 addr3 no effect m1");
        host_read(2'd2, 32'h0008_0000, "R4 addr3 no effect m2");

        send_with_write(mbid[9] ^ 32'h0000_0100, 2'd0, 32'h0, "R12 old mask used");
        send(mbid[9] ^ 32'h0000_0100, "R12 new mask after write");

        for (int n = 0; n < 80; n++) begin
            logic [31:0] w;
            w = mbid[$urandom_range(15)];
            if ($urandom_range(3) == 0) w = w ^ (32'h1 << $urandom_range(31));
            mb_rx_en = 16'($urandom);
            if ($urandom_range(4) == 0)
                send_with_write(w, 2'($urandom_range(3)), $urandom, "R12 random overlap");
            else
                send(w, "R3 random frame");
        end
        mb_rx_en = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(!res_valid && match_vec == 0 && !hit_valid, "R10 idle outputs",
              32'(match_vec), 0);
        check(exp_q.size() == 0, "R10 results drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule